// File: doc/BRIEF.md
# Ethernet MAC transmit frame sequencer

The sequencer pulls frame bytes from a show-ahead transmit FIFO and drives them onto a byte-wide transmit interface that is qualified by a transmit enable. A frame starts only when the MAC is enabled and the FIFO holds at least a programmable watermark of bytes. It is then sent in this order: a fixed preamble, the start-of-frame delimiter, the payload, optional zero padding and an optional 32-bit frame check sequence. On every byte, bit 0 of the transmit data is the bit that goes onto the wire first. The CRC is computed in that bit order.

Two control bits are sampled when the frame starts. One appends the FCS, and short frames are padded only when this bit is set. The other forces a corrupted FCS, and it wins over the first. An over-length frame raises a babble flag when it completes, but it is still sent in full. If the FIFO runs dry before the byte marked last, the frame is abandoned and an underrun flag pulses. A normal frame ends with a one-cycle completion pulse.

Top module: `mac_tx_sequencer`

## Requirements
- R1: No frame starts (tx_en stays 0) unless mac_en is 1, fifo_level >= watermark and the FIFO is not empty. When all three hold in the idle state, a frame starts.
- R2: A frame opens with seven 0x55 bytes and then one 0xD5 byte on tx_d. tx_en is 1 from the first preamble byte through the final byte. tx_d[0] is the first bit on the wire.
- R3: Payload bytes appear in FIFO order, and each is popped exactly once (fifo_rd is high for one cycle per byte). When ctl_fcs is 1, four FCS bytes follow, least significant byte first. The FCS is the reflected CRC-32 (polynomial 0x04C11DB7, seed 0xFFFFFFFF, final inversion) over the payload and pad bytes.
- R4: When ctl_bad_fcs is 1, the four bytes appended are the bitwise inverse of the correct FCS. This holds whatever the value of ctl_fcs.
- R5: When ctl_fcs is 1 and the payload is shorter than 60 bytes, 0x00 bytes extend it to 60. When ctl_fcs is 0, no padding is sent.
- R6: If the byte count after the delimiter (payload, pad and FCS) exceeds max_len, babble is 1 in the frame_done cycle. The frame is still sent without truncation. Otherwise babble stays 0.
- R7: If the FIFO is empty while a byte is owed before the last-marked byte, underrun pulses for one cycle, tx_en is 0 in that same cycle, and frame_done is not raised.
- R8: frame_done is a one-cycle pulse in the cycle right after the final byte of the frame, and tx_en is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mac_en | input | 1 | Transmitter enable |
| watermark | input | LVL_W | FIFO level needed to start a frame |
| fifo_level | input | LVL_W | Bytes currently held in the FIFO |
| fifo_empty | input | 1 | FIFO holds no byte |
| fifo_data | input | 8 | Head byte of the FIFO |
| fifo_last | input | 1 | Head byte is the last byte of its frame |
| fifo_rd | output | 1 | Pops the head byte |
| ctl_fcs | input | 1 | Append FCS and pad short frames |
| ctl_bad_fcs | input | 1 | Append an inverted FCS |
| max_len | input | LEN_W | Largest byte count after the delimiter that raises no babble |
| tx_en | output | 1 | Transmit enable |
| tx_d | output | 8 | Transmit byte, bit 0 first on the wire |
| frame_done | output | 1 | Frame completed pulse |
| babble | output | 1 | Frame exceeded max_len, valid with frame_done |
| underrun | output | 1 | FIFO ran dry mid-frame pulse |

## Verification
The completion pulse and the babble flag are produced in the same cycle, so the critical case is a frame whose total length sits exactly on the max_len boundary. The bench sends a 60-byte payload with FCS against a limit of 64, where no babble may appear with the done pulse. It then sends a 61-byte payload, where babble must coincide with the done pulse and all 65 bytes must still be delivered. A separate case uses a small limit against a frame without FCS, which shows that the count covers only the bytes actually sent.

// File: rtl/txseq_pkg.sv
package txseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_SFD, ST_DATA, ST_PAD, ST_FCS, ST_DONE
  } tx_state_e;

  localparam logic [7:0]  PRE_BYTE   = 8'h55;
  localparam logic [7:0]  SFD_BYTE   = 8'hD5;
  localparam logic [31:0] CRC_POLY_R = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED   = 32'hFFFFFFFF;
endpackage

// File: rtl/txseq_crc.sv
module txseq_crc
  import txseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        upd,
  input  logic [7:0]  din,
  output logic [31:0] crc_q
);
  logic [31:0] stage [0:8];
  logic [31:0] crc_d;

  assign stage[0] = crc_q ^ {24'd0, din};

  // one reflected shift per bit, bit 0 of the byte first
  for (genvar b = 0; b < 8; b++) begin : g_bit
    assign stage[b+1] = stage[b][0] ? ((stage[b] >> 1) ^ CRC_POLY_R)
                                    : (stage[b] >> 1);
  end

  always_comb begin
    crc_d = crc_q;
    if (init)     crc_d = CRC_SEED;
    else if (upd) crc_d = stage[8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_SEED;
    else        crc_q <= crc_d;
  end
endmodule

// File: rtl/txseq_count.sv
module txseq_count #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [LEN_W-1:0] max_len,
  output logic [LEN_W-1:0] len_q,
  output logic             over
);
  localparam logic [LEN_W-1:0] LEN_TOP = '1;
  logic [LEN_W-1:0] len_d;

  always_comb begin
    len_d = len_q;
    if (clr)                         len_d = '0;
    else if (inc && len_q != LEN_TOP) len_d = len_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) len_q <= '0;
    else        len_q <= len_d;
  end

  assign over = (len_q > max_len);

  // R6: the byte counter never wraps back to zero without a clear
  len_nowrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(len_q) == LEN_TOP && !$past(clr)) |-> len_q == LEN_TOP);
endmodule

// File: rtl/txseq_ctrl.sv
module txseq_ctrl
  import txseq_pkg::*;
#(
  parameter int LVL_W    = 8,
  parameter int LEN_W    = 16,
  parameter int PRE_LEN  = 7,
  parameter int MIN_DATA = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mac_en,
  input  logic [LVL_W-1:0] watermark,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             fifo_empty,
  input  logic [7:0]       fifo_data,
  input  logic             fifo_last,
  input  logic             ctl_fcs,
  input  logic             ctl_bad_fcs,
  input  logic [LEN_W-1:0] len_q,
  input  logic             over,
  input  logic [31:0]      crc_q,
  output logic             fifo_rd,
  output logic             crc_init,
  output logic             crc_upd,
  output logic [7:0]       crc_din,
  output logic             len_clr,
  output logic             len_inc,
  output logic             tx_en,
  output logic [7:0]       tx_d,
  output logic             frame_done,
  output logic             babble,
  output logic             underrun
);
  localparam logic [2:0]       PRE_LAST = 3'(PRE_LEN - 1);
  localparam logic [LEN_W-1:0] PAD_LAST = LEN_W'(MIN_DATA - 1);

  tx_state_e  st_q, st_d;
  logic [2:0] cnt_q, cnt_d;
  logic       fcs_q, fcs_d;     // append-FCS latched at start
  logic       bad_q, bad_d;     // force-bad latched at start
  logic       en_d, done_d, bab_d, und_d;
  logic [7:0] byte_d;
  logic [31:0] fcs_val;
  logic       start;

  assign start   = mac_en && !fifo_empty && (fifo_level >= watermark);
  assign fifo_rd = (st_q == ST_DATA) && !fifo_empty;
  assign fcs_val = bad_q ? crc_q : ~crc_q;

  assign crc_init = (st_q == ST_SFD);
  assign len_clr  = (st_q == ST_SFD);
  assign crc_upd  = fifo_rd || (st_q == ST_PAD);
  assign crc_din  = (st_q == ST_PAD) ? 8'h00 : fifo_data;
  assign len_inc  = fifo_rd || (st_q == ST_PAD) || (st_q == ST_FCS);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    fcs_d  = fcs_q;
    bad_d  = bad_q;
    en_d   = 1'b0;
    byte_d = 8'h00;
    done_d = 1'b0;
    bab_d  = 1'b0;
    und_d  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d  = ST_PRE;
          cnt_d = '0;
          fcs_d = ctl_fcs;
          bad_d = ctl_bad_fcs;
        end
      end
      ST_PRE: begin
        en_d   = 1'b1;
        byte_d = PRE_BYTE;
        cnt_d  = cnt_q + 3'd1;
        if (cnt_q == PRE_LAST) st_d = ST_SFD;
      end
      ST_SFD: begin
        en_d   = 1'b1;
        byte_d = SFD_BYTE;
        st_d   = ST_DATA;
      end
      ST_DATA: begin
        if (fifo_empty) begin
          und_d = 1'b1;
          st_d  = ST_IDLE;
        end else begin
          en_d   = 1'b1;
          byte_d = fifo_data;
          if (fifo_last) begin
            cnt_d = '0;
            if (fcs_q && len_q < PAD_LAST) st_d = ST_PAD;
            else if (fcs_q || bad_q)       st_d = ST_FCS;
            else                           st_d = ST_DONE;
          end
        end
      end
      ST_PAD: begin
        en_d   = 1'b1;
        byte_d = 8'h00;
        if (len_q >= PAD_LAST) st_d = ST_FCS;
      end
      ST_FCS: begin
        en_d   = 1'b1;
        byte_d = fcs_val[8*cnt_q[1:0] +: 8];
        cnt_d  = cnt_q + 3'd1;
        if (cnt_q == 3'd3) st_d = ST_DONE;
      end
      ST_DONE: begin
        done_d = 1'b1;
        bab_d  = over;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      fcs_q      <= 1'b0;
      bad_q      <= 1'b0;
      tx_en      <= 1'b0;
      tx_d       <= 8'h00;
      frame_done <= 1'b0;
      babble     <= 1'b0;
      underrun   <= 1'b0;
    end else begin
      st_q       <= st_d;
      cnt_q      <= cnt_d;
      fcs_q      <= fcs_d;
      bad_q      <= bad_d;
      tx_en      <= en_d;
      tx_d       <= byte_d;
      frame_done <= done_d;
      babble     <= bab_d;
      underrun   <= und_d;
    end
  end

  // R8
  done_en_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !tx_en);
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  // R8
  en_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_en) |-> (frame_done || underrun));
  // R6
  babble_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    babble |-> frame_done);
  // R7
  underrun_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> (!frame_done && !tx_en));
  // R2
  first_byte_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> tx_d == PRE_BYTE);
endmodule

// File: rtl/mac_tx_sequencer.sv
module mac_tx_sequencer #(
  parameter int LVL_W    = 8,
  parameter int LEN_W    = 16,
  parameter int PRE_LEN  = 7,
  parameter int MIN_DATA = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mac_en,
  input  logic [LVL_W-1:0] watermark,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             fifo_empty,
  input  logic [7:0]       fifo_data,
  input  logic             fifo_last,
  output logic             fifo_rd,
  input  logic             ctl_fcs,
  input  logic             ctl_bad_fcs,
  input  logic [LEN_W-1:0] max_len,
  output logic             tx_en,
  output logic [7:0]       tx_d,
  output logic             frame_done,
  output logic             babble,
  output logic             underrun
);
  logic             crc_init, crc_upd, len_clr, len_inc, over;
  logic [7:0]       crc_din;
  logic [31:0]      crc_q;
  logic [LEN_W-1:0] len_q;

  txseq_ctrl #(
    .LVL_W(LVL_W), .LEN_W(LEN_W), .PRE_LEN(PRE_LEN), .MIN_DATA(MIN_DATA)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n), .mac_en(mac_en), .watermark(watermark),
    .fifo_level(fifo_level), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
    .fifo_last(fifo_last), .ctl_fcs(ctl_fcs), .ctl_bad_fcs(ctl_bad_fcs),
    .len_q(len_q), .over(over), .crc_q(crc_q), .fifo_rd(fifo_rd),
    .crc_init(crc_init), .crc_upd(crc_upd), .crc_din(crc_din),
    .len_clr(len_clr), .len_inc(len_inc), .tx_en(tx_en), .tx_d(tx_d),
    .frame_done(frame_done), .babble(babble), .underrun(underrun)
  );

  txseq_crc i_crc (
    .clk(clk), .rst_n(rst_n), .init(crc_init), .upd(crc_upd),
    .din(crc_din), .crc_q(crc_q)
  );

  txseq_count #(.LEN_W(LEN_W)) i_count (
    .clk(clk), .rst_n(rst_n), .clr(len_clr), .inc(len_inc),
    .max_len(max_len), .len_q(len_q), .over(over)
  );
endmodule

// File: tb/test_mac_tx_sequencer.sv
module test_mac_tx_sequencer;
  localparam int LVL_W = 8;
  localparam int LEN_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mac_en = 1'b0;
  logic [LVL_W-1:0] watermark = 8'd1;
  logic ctl_fcs = 1'b0, ctl_bad_fcs = 1'b0;
  logic [LEN_W-1:0] max_len = 16'd1518;
  logic [LVL_W-1:0] fifo_level;
  logic fifo_empty, fifo_last, fifo_rd;
  logic [7:0] fifo_data;
  logic tx_en, frame_done, babble, underrun;
  logic [7:0] tx_d;

  always #10 clk = ~clk;

  // bench FIFO model, show-ahead
  logic [7:0] fm [0:1023];
  logic       fl [0:1023];
  int wp = 0, rp = 0;
  always @(posedge clk) if (fifo_rd) rp <= rp + 1;
  assign fifo_empty = (wp == rp);
  assign fifo_level = LVL_W'(((wp - rp) > 255) ? 255 : (wp - rp));
  assign fifo_data  = fm[rp % 1024];
  assign fifo_last  = fl[rp % 1024];

  mac_tx_sequencer i_mac_tx_sequencer (
    .clk(clk), .rst_n(rst_n), .mac_en(mac_en), .watermark(watermark),
    .fifo_level(fifo_level), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
    .fifo_last(fifo_last), .fifo_rd(fifo_rd), .ctl_fcs(ctl_fcs),
    .ctl_bad_fcs(ctl_bad_fcs), .max_len(max_len), .tx_en(tx_en), .tx_d(tx_d),
    .frame_done(frame_done), .babble(babble), .underrun(underrun)
  );

  int nchk = 0, nfail = 0;
  int cap [0:255];
  int ncap = 0, ndone = 0, nund = 0, nbab = 0, npop = 0;
  bit done_bad = 0, und_bad = 0, prev_en = 0;
  bit bab_seen = 0;
  logic [7:0] dat [0:255];

  // monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_en && ncap < 256) begin cap[ncap] = int'(tx_d); ncap = ncap + 1; end
      if (fifo_rd) npop = npop + 1;
      if (frame_done) begin
        ndone = ndone + 1;
        if (tx_en || !prev_en) done_bad = 1;
        if (babble) bab_seen = 1;
      end
      if (babble) nbab = nbab + 1;
      if (underrun) begin
        nund = nund + 1;
        if (tx_en) und_bad = 1;
      end
      prev_en = tx_en;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk = nchk + 1;
    if (!ok) begin
      nfail = nfail + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  task automatic clear_mon();
    ncap = 0; ndone = 0; nund = 0; nbab = 0; npop = 0;
    done_bad = 0; und_bad = 0; bab_seen = 0;
  endtask

  task automatic push(input int n, input int from, input int seed, input bit mark_last);
    @(negedge clk);
    for (int i = from; i < n; i++) begin
      dat[i] = 8'((seed + i * 37) & 255);
      fm[wp % 1024] = dat[i];
      fl[wp % 1024] = mark_last && (i == n - 1);
      wp = wp + 1;
    end
  endtask

  task automatic wait_end();
    int t = 0;
    while (ndone == 0 && nund == 0 && t < 3000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
  endtask

  // compares the captured frame against one built from the requirements
  task automatic verify(input int n, input bit crc, input bit bad, input int maxl);
    int exp_b [0:255];
    int ne = 0, dl, mism = 0, total;
    logic [31:0] c = 32'hFFFFFFFF, f;
    for (int i = 0; i < 7; i++) begin exp_b[ne] = 8'h55; ne++; end
    exp_b[ne] = 8'hD5; ne++;
    dl = (crc && n < 60) ? 60 : n;
    for (int i = 0; i < dl; i++) begin
      logic [7:0] b = (i < n) ? dat[i] : 8'h00;
      exp_b[ne] = int'(b); ne++;
      c = crc_step(c, b);
    end
    f = bad ? c : ~c;
    if (crc || bad)
      for (int k = 0; k < 4; k++) begin exp_b[ne] = int'(f[8*k +: 8]); ne++; end
    total = ne - 8;
    chk(ncap == ne, "R5 frame length on wire", ncap, ne);
    for (int i = 0; i < 8 && i < ncap; i++) if (cap[i] != exp_b[i]) mism++;
    chk(mism == 0, "R2 preamble and delimiter", mism, 0);
    mism = 0;
    for (int i = 8; i < 8 + n && i < ncap; i++) if (cap[i] != exp_b[i]) mism++;
    chk(mism == 0, "R3 payload bytes", mism, 0);
    chk(npop == n, "R3 pops per frame", npop, n);
    mism = 0;
    for (int i = 8 + n; i < ne && i < ncap; i++) if (cap[i] != exp_b[i]) mism++;
    chk(mism == 0, bad ? "R4 inverted FCS" : "R5 pad and R3 FCS", mism, 0);
    chk(ndone == 1 && !done_bad, "R8 done pulse timing", ndone, 1);
    chk(nund == 0, "R7 no underrun", nund, 0);
    chk(bab_seen == (total > maxl) && nbab == int'(total > maxl),
        "R6 babble flag", nbab, int'(total > maxl));
  endtask

  task automatic run_frame(input int n, input bit crc, input bit bad, input int maxl, input int seed);
    ctl_fcs = crc; ctl_bad_fcs = bad; max_len = LEN_W'(maxl);
    clear_mon();
    push(n, 0, seed, 1);
    wait_end();
    verify(n, crc, bad, maxl);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!tx_en && !frame_done && !babble && !underrun && !fifo_rd,
        "R1 reset outputs idle", int'(tx_en), 0);
  endtask

  task automatic t_gating();
    // R1: MAC disabled, data present
    mac_en = 0; watermark = 8'd1; ctl_fcs = 1; ctl_bad_fcs = 0; max_len = 16'd1518;
    clear_mon();
    push(4, 0, 11, 0);
    repeat (20) @(negedge clk);
    chk(ncap == 0, "R1 disabled MAC holds", ncap, 0);
    // R1: enabled but below watermark
    watermark = 8'd12; mac_en = 1;
    repeat (20) @(negedge clk);
    chk(ncap == 0, "R1 below watermark holds", ncap, 0);
    push(11, 4, 11, 0);
    repeat (20) @(negedge clk);
    chk(ncap == 0, "R1 one short of watermark", ncap, 0);
    push(12, 11, 11, 1);
    wait_end();
    verify(12, 1, 0, 1518);
    watermark = 8'd1;
  endtask

  task automatic t_underrun();
    ctl_fcs = 1; ctl_bad_fcs = 0;
    clear_mon();
    push(5, 0, 3, 0);
    wait_end();
    chk(nund == 1 && !und_bad, "R7 underrun pulse with tx_en low", nund, 1);
    chk(ndone == 0, "R7 no done after underrun", ndone, 0);
    chk(ncap == 13, "R7 bytes before abort", ncap, 13);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_gating();
    mac_en = 1;
    run_frame(10, 0, 0, 1518, 5);   // R5 no pad without FCS
    run_frame(20, 1, 0, 1518, 9);   // R3 R5 pad plus FCS
    run_frame(20, 1, 1, 1518, 21);  // R4 bad wins over append
    run_frame(20, 0, 1, 1518, 33);  // R4 bad alone, no pad
    run_frame(70, 1, 0, 1518, 44);  // R3 long frame, no pad
    run_frame(60, 1, 0, 64, 55);    // R6 exactly at limit
    run_frame(61, 1, 0, 64, 66);    // R6 one over, full frame sent
    run_frame(20, 0, 0, 10, 77);    // R6 small limit without FCS
    t_underrun();
    run_frame(10, 1, 0, 1518, 88);  // R1 recovers after underrun
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk = nchk + 1;
    nfail = nfail + 1;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule